// File: doc/BRIEF.md
# Two-Stage Segmented-Paged Address Translator

This block turns a virtual address into a physical address in two stages. The top bits of the virtual address pick one of a small set of segments that are kept in on-chip registers. Each segment has a valid flag, read/write/execute permissions, the base address of its page table in memory and a page limit. The middle bits are a page number. The block compares the page number with the segment's limit, and no memory access happens unless the page number is within the limit. It then reads one page table entry from memory. That entry supplies a frame number and page-level permissions. The low bits of the virtual address pass through unchanged as the offset.

Only one translation runs at a time. A requester presents an address and an access type while the block is not busy. It then waits for a one-cycle done pulse, which comes with the physical address and a fault code. Software or a neighbouring controller loads segment entries through a write port. A write that arrives while a translation is running is dropped, so the segment used by the running translation cannot change under it. Any translation cache in front of the block is outside its scope.

Top module: `pst_translator`

## Requirements
- R1: After reset `busy`, `done` and `memReq` are low and every segment entry is invalid, so the first request faults with the segment-invalid code.
- R2: With the default widths, virtual address bits [31:30] select the segment, bits [29:12] are the page number and bits [11:0] are the offset.
- R3: A request to a segment whose valid flag is clear finishes with fault code 1 and raises no memory request; this fault takes priority over every other fault.
- R4: A page number greater than the segment's limit gives fault code 2 without a memory request; a page number equal to the limit proceeds to memory.
- R5: The entry address is the segment base plus four times the page number; `memReq` stays high, with `memAddr` unchanged, until the cycle in which `memAck` is sampled high.
- R6: A page table entry word holds the valid flag in bit 0, read/write/execute permissions in bits 1, 2 and 3, and the frame number in bits [31:12]; an entry with bit 0 clear gives fault code 3.
- R7: A permitted translation gives fault code 0 and a physical address equal to the frame number joined above the unchanged 12-bit offset.
- R8: Access codes are 0 read, 1 write and 2 execute; code 3 is never permitted. Segment permissions (bit 0 read, bit 1 write, bit 2 execute) are checked before memory, and a denial gives fault code 4 with no memory request. A denial by the page permissions gives fault code 4 after the read.
- R9: A request is accepted when `reqValid` is high and `busy` is low. `busy` is high from the next cycle through the done cycle, and `done` is a one-cycle pulse. Requests made while busy are ignored, and `paddr`/`fault` hold their values until the next done.
- R10: A segment write while `busy` is high has no effect; a write while idle applies to the next request.
- R11: Every faulting result reports a physical address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqVa | input | 32 | Virtual address |
| reqAccess | input | 2 | Access type: 0 read, 1 write, 2 execute |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle result strobe |
| paddr | output | 32 | Physical address result |
| fault | output | 3 | 0 ok, 1 segment invalid, 2 over limit, 3 page invalid, 4 permission |
| segWrEn | input | 1 | Segment entry write strobe |
| segWrIdx | input | 2 | Segment entry to write |
| segWrValid | input | 1 | Valid flag to write |
| segWrPerm | input | 3 | Segment permissions (read, write, execute) |
| segWrBase | input | 32 | Page table base address |
| segWrLimit | input | 18 | Highest allowed page number |
| memReq | output | 1 | Page table entry read request |
| memAddr | output | 32 | Byte address of the entry |
| memAck | input | 1 | Read data valid |
| memRdata | input | 32 | Page table entry word |

## Verification
The bench builds the block with its default widths: four segments, an 18-bit page number and a 20-bit frame. All four segment slots can therefore be written, and the limit boundary can be tested at the exact page next to the limit. The bench's memory model answers after a latency that the tests change, from zero up to twenty cycles. The long waits keep a translation busy long enough to send competing segment writes and requests during it. The tests also cover each fault source, the order in which faults take priority, and the difference between denials made before the memory read and denials made after it.

// File: rtl/pst_pkg.sv
package pst_pkg;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_SEG_OFF  = 3'd1,
    FLT_LIMIT    = 3'd2,
    FLT_PAGE_OFF = 3'd3,
    FLT_PERM     = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_DONE
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;    // capture virtual address and access type
    logic loadEarly; // load result from the pre-memory checks
    logic loadPte;   // load result from the fetched entry
  } strobe_t;

  localparam int PERM_W = 3;

  // perm[0] read, perm[1] write, perm[2] execute; access code 3 never allowed
  function automatic logic accessOk(input logic [PERM_W-1:0] perm,
                                    input logic [1:0] acc);
    case (acc)
      2'd0:    return perm[0];
      2'd1:    return perm[1];
      2'd2:    return perm[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pst_seg_table.sv
module pst_seg_table
  import pst_pkg::*;
#(
  parameter int SEG_W  = 2,
  parameter int PAGE_W = 18,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEG_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic [PERM_W-1:0] wrPerm,
  input  logic [BASE_W-1:0] wrBase,
  input  logic [PAGE_W-1:0] wrLimit,
  input  logic [SEG_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [PERM_W-1:0] rdPerm,
  output logic [BASE_W-1:0] rdBase,
  output logic [PAGE_W-1:0] rdLimit
);
  localparam int SEG_N = 1 << SEG_W;

  logic              validQ [SEG_N];
  logic [PERM_W-1:0] permQ  [SEG_N];
  logic [BASE_W-1:0] baseQ  [SEG_N];
  logic [PAGE_W-1:0] limitQ [SEG_N];

  for (genvar i = 0; i < SEG_N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        permQ[i]  <= '0;
        baseQ[i]  <= '0;
        limitQ[i] <= '0;
      end else if (wrEn && wrIdx == SEG_W'(i)) begin
        validQ[i] <= wrValid;
        permQ[i]  <= wrPerm;
        baseQ[i]  <= wrBase;
        limitQ[i] <= wrLimit;
      end
    end
  end

  assign rdValid = validQ[rdIdx];
  assign rdPerm  = permQ[rdIdx];
  assign rdBase  = baseQ[rdIdx];
  assign rdLimit = limitQ[rdIdx];

endmodule

// File: rtl/pst_control.sv
module pst_control
  import pst_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  fault_e  earlyFault,
  input  logic    memAck,
  output strobe_t strobe,
  output logic    busy,
  output logic    done,
  output logic    memReq
);
  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        strobe.capReq = 1'b1;
        stateD        = ST_CHECK;
      end
      ST_CHECK: begin
        if (earlyFault != FLT_NONE) begin
          strobe.loadEarly = 1'b1;
          stateD           = ST_DONE;
        end else begin
          stateD = ST_FETCH;
        end
      end
      ST_FETCH: if (memAck) begin
        strobe.loadPte = 1'b1;
        stateD         = ST_DONE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy   = (stateQ != ST_IDLE);
  assign done   = (stateQ == ST_DONE);
  assign memReq = (stateQ == ST_FETCH);

endmodule

// File: rtl/pst_datapath.sv
module pst_datapath
  import pst_pkg::*;
#(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 18,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int MEM_AW  = 32,
  parameter int MEM_DW  = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strobe,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0]    reqVa,
  input  logic [1:0]                       reqAccess,
  output logic [SEG_W-1:0]                 segIdx,
  input  logic                             segValid,
  input  logic [PERM_W-1:0]                segPerm,
  input  logic [MEM_AW-1:0]                segBase,
  input  logic [PAGE_W-1:0]                segLimit,
  output fault_e                           earlyFault,
  output logic [MEM_AW-1:0]                memAddr,
  input  logic [MEM_DW-1:0]                memRdata,
  output logic [FRAME_W+OFF_W-1:0]         paddr,
  output fault_e                           fault
);
  localparam int VA_W    = SEG_W + PAGE_W + OFF_W;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int PTE_LOW = PERM_W + 1;

  logic [VA_W-1:0]   vaQ;
  logic [1:0]        accQ;
  logic [PAGE_W-1:0] pageNum;
  logic [OFF_W-1:0]  offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ  <= '0;
      accQ <= '0;
    end else if (strobe.capReq) begin
      vaQ  <= reqVa;
      accQ <= reqAccess;
    end
  end

  assign segIdx  = vaQ[VA_W-1 -: SEG_W];
  assign pageNum = vaQ[OFF_W +: PAGE_W];
  assign offset  = vaQ[OFF_W-1:0];

  // Stage one: segment checks, in priority order
  always_comb begin
    if (!segValid)                    earlyFault = FLT_SEG_OFF;
    else if (pageNum > segLimit)      earlyFault = FLT_LIMIT;
    else if (!accessOk(segPerm, accQ)) earlyFault = FLT_PERM;
    else                              earlyFault = FLT_NONE;
  end

  assign memAddr = segBase + (MEM_AW'(pageNum) << 2);

  // Stage two: entry decode
  logic               pteValid;
  logic [PERM_W-1:0]  ptePerm;
  logic [FRAME_W-1:0] pteFrame;
  logic               unusedPteBits;

  assign pteValid      = memRdata[0];
  assign ptePerm       = memRdata[PERM_W:1];
  assign pteFrame      = memRdata[MEM_DW-1 -: FRAME_W];
  assign unusedPteBits = ^memRdata[MEM_DW-FRAME_W-1:PTE_LOW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddr <= '0;
      fault <= FLT_NONE;
    end else if (strobe.loadEarly) begin
      paddr <= '0;
      fault <= earlyFault;
    end else if (strobe.loadPte) begin
      if (!pteValid) begin
        paddr <= '0;
        fault <= FLT_PAGE_OFF;
      end else if (!accessOk(ptePerm, accQ)) begin
        paddr <= '0;
        fault <= FLT_PERM;
      end else begin
        paddr <= PA_W'({pteFrame, offset});
        fault <= FLT_NONE;
      end
    end
  end

endmodule

// File: rtl/pst_translator.sv
module pst_translator
  import pst_pkg::*;
#(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 18,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int MEM_AW  = 32,
  parameter int MEM_DW  = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0]  reqVa,
  input  logic [1:0]                     reqAccess,
  output logic                           busy,
  output logic                           done,
  output logic [FRAME_W+OFF_W-1:0]       paddr,
  output logic [2:0]                     fault,
  input  logic                           segWrEn,
  input  logic [SEG_W-1:0]               segWrIdx,
  input  logic                           segWrValid,
  input  logic [PERM_W-1:0]              segWrPerm,
  input  logic [MEM_AW-1:0]              segWrBase,
  input  logic [PAGE_W-1:0]              segWrLimit,
  output logic                           memReq,
  output logic [MEM_AW-1:0]              memAddr,
  input  logic                           memAck,
  input  logic [MEM_DW-1:0]              memRdata
);
  strobe_t            strobe;
  fault_e             earlyFault;
  fault_e             faultQ;
  logic [SEG_W-1:0]   segIdx;
  logic               segValid;
  logic [PERM_W-1:0]  segPerm;
  logic [MEM_AW-1:0]  segBase;
  logic [PAGE_W-1:0]  segLimit;
  logic               tableWrEn;

  assign tableWrEn = segWrEn && !busy;
  assign fault     = faultQ;

  pst_seg_table #(.SEG_W(SEG_W), .PAGE_W(PAGE_W), .BASE_W(MEM_AW)) u_segtab (
    .clk(clk), .rstN(rstN),
    .wrEn(tableWrEn), .wrIdx(segWrIdx), .wrValid(segWrValid),
    .wrPerm(segWrPerm), .wrBase(segWrBase), .wrLimit(segWrLimit),
    .rdIdx(segIdx), .rdValid(segValid), .rdPerm(segPerm),
    .rdBase(segBase), .rdLimit(segLimit)
  );

  pst_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .earlyFault(earlyFault),
    .memAck(memAck), .strobe(strobe), .busy(busy), .done(done), .memReq(memReq)
  );

  pst_datapath #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W),
    .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVa(reqVa), .reqAccess(reqAccess),
    .segIdx(segIdx), .segValid(segValid), .segPerm(segPerm), .segBase(segBase),
    .segLimit(segLimit), .earlyFault(earlyFault), .memAddr(memAddr),
    .memRdata(memRdata), .paddr(paddr), .fault(faultQ)
  );

endmodule

// File: rtl/pst_translator_checker.sv
module pst_translator_checker #(
  parameter int PA_W   = 32,
  parameter int MEM_AW = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memAck,
  input logic [MEM_AW-1:0] memAddr,
  input logic [PA_W-1:0]   paddr,
  input logic [2:0]        fault
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_mem_only_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  assert_no_mem_first_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !memReq);

  assert_hold_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  assert_fault_zero_addr_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault != 3'd0) |-> (paddr == '0));

  assert_fault_code_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fault <= 3'd4));
endmodule

bind pst_translator pst_translator_checker #(
  .PA_W(FRAME_W + OFF_W), .MEM_AW(MEM_AW)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .memReq(memReq),
  .memAck(memAck), .memAddr(memAddr), .paddr(paddr), .fault(fault)
);

// File: tb/pst_translator_test.sv
`timescale 1ns/1ps
module pst_translator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [1:0]  reqAccess = '0;
  logic        busy, done, memReq;
  logic [31:0] paddr, memAddr;
  logic [2:0]  fault;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrIdx = '0;
  logic        segWrValid = 1'b0;
  logic [2:0]  segWrPerm = '0;
  logic [31:0] segWrBase = '0;
  logic [17:0] segWrLimit = '0;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  always #2.5 clk = ~clk;

  pst_translator uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
    .reqAccess(reqAccess), .busy(busy), .done(done), .paddr(paddr),
    .fault(fault), .segWrEn(segWrEn), .segWrIdx(segWrIdx),
    .segWrValid(segWrValid), .segWrPerm(segWrPerm), .segWrBase(segWrBase),
    .segWrLimit(segWrLimit), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memRdata(memRdata)
  );

  int nRun = 0;
  int nFail = 0;

  // Memory model: word array, fixed latency, tracks fetch count and address hold
  logic [31:0] pteMem [0:1023];
  int          memLat = 0;
  int          waitCnt = 0;
  int          fetches = 0;
  int          addrSlips = 0;
  logic [31:0] lastAddr = '0;
  logic [31:0] heldAddr = '0;

  always @(negedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      if (waitCnt != 0 && memAddr != heldAddr) addrSlips <= addrSlips + 1;
      heldAddr <= memAddr;
      if (waitCnt >= memLat) begin
        memAck   <= 1'b1;
        memRdata <= pteMem[memAddr[11:2]];
        lastAddr <= memAddr;
        fetches  <= fetches + 1;
        waitCnt  <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkVa(input logic [1:0] s, input logic [17:0] p,
                                       input logic [11:0] o);
    return {s, p, o};
  endfunction

  function automatic logic [31:0] mkPte(input logic [19:0] fr, input logic [2:0] perm,
                                        input logic v);
    return {fr, 8'h00, perm, v};
  endfunction

  task automatic segWrite(input logic [1:0] idx, input logic v, input logic [2:0] perm,
                          input logic [31:0] base, input logic [17:0] lim);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = idx; segWrValid = v; segWrPerm = perm;
    segWrBase = base; segWrLimit = lim;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [1:0] acc,
                       output logic [31:0] pa, output logic [2:0] flt);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqAccess = acc;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) check(1'b0, "R9 done timeout", 32'(n), 32'd200);
    pa = paddr; flt = fault;
  endtask

  task automatic testReset();
    logic [31:0] pa; logic [2:0] f; int f0;
    check(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
    check(done == 1'b0, "R1 done after reset", 32'(done), 0);
    check(memReq == 1'b0, "R1 memReq after reset", 32'(memReq), 0);
    f0 = fetches;
    xlate(mkVa(2'd0, 18'd0, 12'h0), 2'd0, pa, f);
    check(f == 3'd1, "R1 segment invalid after reset", 32'(f), 1);
    check(fetches == f0, "R3 no fetch on invalid segment", 32'(fetches), 32'(f0));
    check(pa == 0, "R11 faulting address zero", pa, 0);
  endtask

  task automatic testBasic();
    logic [31:0] pa; logic [2:0] f;
    segWrite(2'd1, 1'b1, 3'b111, 32'h400, 18'd10);
    pteMem[(32'h400 + 4 * 3) >> 2] = mkPte(20'hABCDE, 3'b111, 1'b1);
    memLat = 0;
    xlate(mkVa(2'd1, 18'd3, 12'h5A5), 2'd0, pa, f);
    check(f == 3'd0, "R7 success fault code", 32'(f), 0);
    check(pa == 32'hABCDE5A5, "R7 physical address", pa, 32'hABCDE5A5);
    check(lastAddr == 32'h40C, "R5 entry address", lastAddr, 32'h40C);
    // different offset and latency, checks R2 field split
    memLat = 5;
    xlate(mkVa(2'd1, 18'd3, 12'hFFF), 2'd0, pa, f);
    check(pa == 32'hABCDEFFF, "R2 offset passes unchanged", pa, 32'hABCDEFFF);
    check(addrSlips == 0, "R5 address held while waiting", 32'(addrSlips), 0);
  endtask

  task automatic testLimit();
    logic [31:0] pa; logic [2:0] f; int f0;
    pteMem[(32'h400 + 4 * 10) >> 2] = mkPte(20'h12345, 3'b111, 1'b1);
    memLat = 2;
    xlate(mkVa(2'd1, 18'd10, 12'h010), 2'd0, pa, f);
    check(f == 3'd0 && pa == 32'h12345010, "R4 page equal to limit", pa, 32'h12345010);
    f0 = fetches;
    xlate(mkVa(2'd1, 18'd11, 12'h010), 2'd0, pa, f);
    check(f == 3'd2, "R4 page over limit", 32'(f), 2);
    check(fetches == f0, "R4 no fetch over limit", 32'(fetches), 32'(f0));
  endtask

  task automatic testPageInvalid();
    logic [31:0] pa; logic [2:0] f;
    pteMem[(32'h400 + 4 * 5) >> 2] = mkPte(20'h77777, 3'b111, 1'b0);
    xlate(mkVa(2'd1, 18'd5, 12'h123), 2'd0, pa, f);
    check(f == 3'd3, "R6 invalid entry", 32'(f), 3);
    check(pa == 0, "R11 zero address on invalid entry", pa, 0);
  endtask

  task automatic testPerms();
    logic [31:0] pa; logic [2:0] f; int f0;
    segWrite(2'd2, 1'b1, 3'b001, 32'h800, 18'd20);
    pteMem[(32'h800 + 4 * 1) >> 2] = mkPte(20'h00BEE, 3'b111, 1'b1);
    f0 = fetches;
    xlate(mkVa(2'd2, 18'd1, 12'h004), 2'd1, pa, f);
    check(f == 3'd4, "R8 segment denies write", 32'(f), 4);
    check(fetches == f0, "R8 no fetch on segment denial", 32'(fetches), 32'(f0));
    xlate(mkVa(2'd2, 18'd1, 12'h004), 2'd0, pa, f);
    check(f == 3'd0 && pa == 32'h00BEE004, "R8 segment allows read", pa, 32'h00BEE004);
    // page exec-only under a fully permitted segment
    pteMem[(32'h400 + 4 * 7) >> 2] = mkPte(20'h0CAFE, 3'b100, 1'b1);
    f0 = fetches;
    xlate(mkVa(2'd1, 18'd7, 12'h0AA), 2'd0, pa, f);
    check(f == 3'd4, "R8 page denies read", 32'(f), 4);
    check(fetches == f0 + 1, "R8 page denial after fetch", 32'(fetches), 32'(f0 + 1));
    xlate(mkVa(2'd1, 18'd7, 12'h0AA), 2'd2, pa, f);
    check(f == 3'd0 && pa == 32'h0CAFE0AA, "R8 page allows exec", pa, 32'h0CAFE0AA);
    xlate(mkVa(2'd1, 18'd7, 12'h0AA), 2'd3, pa, f);
    check(f == 3'd4, "R8 access code 3 denied", 32'(f), 4);
  endtask

  task automatic testPriority();
    logic [31:0] pa; logic [2:0] f;
    segWrite(2'd3, 1'b0, 3'b000, 32'hC00, 18'd0);
    xlate(mkVa(2'd3, 18'd99, 12'h0), 2'd3, pa, f);
    check(f == 3'd1, "R3 segment invalid outranks others", 32'(f), 1);
    segWrite(2'd3, 1'b1, 3'b000, 32'hC00, 18'd2);
    xlate(mkVa(2'd3, 18'd3, 12'h0), 2'd0, pa, f);
    check(f == 3'd2, "R4 limit outranks permission", 32'(f), 2);
  endtask

  task automatic testBusy();
    logic [31:0] pa; logic [2:0] f; int n;
    memLat = 20;
    @(negedge clk);
    reqValid = 1'b1; reqVa = mkVa(2'd1, 18'd3, 12'h111); reqAccess = 2'd0;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
    @(negedge clk);
    // competing write and request while busy
    segWrEn = 1'b1; segWrIdx = 2'd1; segWrValid = 1'b0; segWrPerm = 3'b000;
    segWrBase = 32'h0; segWrLimit = 18'd0;
    reqValid = 1'b1; reqVa = mkVa(2'd2, 18'd1, 12'h222);
    @(negedge clk);
    segWrEn = 1'b0; reqValid = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    check(paddr == 32'hABCDE111, "R9 first request result", paddr, 32'hABCDE111);
    @(negedge clk);
    check(done == 1'b0, "R9 done is one cycle", 32'(done), 0);
    check(busy == 1'b0, "R9 busy request dropped", 32'(busy), 0);
    check(paddr == 32'hABCDE111, "R9 result held", paddr, 32'hABCDE111);
    memLat = 1;
    xlate(mkVa(2'd1, 18'd3, 12'h333), 2'd0, pa, f);
    check(f == 3'd0 && pa == 32'hABCDE333, "R10 busy write ignored", pa, 32'hABCDE333);
    segWrite(2'd1, 1'b0, 3'b111, 32'h400, 18'd10);
    xlate(mkVa(2'd1, 18'd3, 12'h333), 2'd0, pa, f);
    check(f == 3'd1, "R10 idle write applies", 32'(f), 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) pteMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testLimit();
    testPageInvalid();
    testPerms();
    testPriority();
    testBusy();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule